// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Byte Lanes

This block is a cycle-accurate model of a synchronous, pipelined burst static RAM. It stores words of four 9-bit byte lanes, 36 bits in all. The number of words is a parameter. Every input except output enable is sampled on the rising clock edge: the address, three chip enables, two address-load strobes, an advance strobe and the write controls. A burst starts when one of the two strobes loads an external address. After that the advance strobe steps the two low address bits internally, in interleaved or linear order. When advance is high the burst holds its address for a wait cycle.

The two strobes are gated differently. The processor strobe counts only while the primary enable is low, and it always starts a read. The controller strobe starts either a read or a write, chosen by the combined write signal. Writes can cover all four lanes through the global write input, or selected lanes through the per-lane strobes. Read data is registered twice, so it reaches the output one edge after the edge that used the address. The output enable gates the data outputs asynchronously. Separate input, output and drive-enable ports take the place of a bidirectional bus.

Top module: `burst_sram`

## Requirements
- R1: While reset is low at a rising edge, and after reset is released until a read is started, `dout_en` is 0 and the burst is inactive.
- R2: `proc_strb_n`=0 with `en_n`=0, `en_hi`=1 and `en_lo_n`=0 at an edge loads `addr` and starts a read. This holds even when the write controls request a write, and memory is not changed.
- R3: When `en_n`=1, `proc_strb_n` is ignored. With `ctl_strb_n`=1 that cycle is treated as a continue or wait cycle of the current burst, not as a new start.
- R4: `ctl_strb_n`=0, with the chip selected and the processor strobe not taken, loads `addr`. It starts a write if the combined write is active, and a read otherwise.
- R5: A taken strobe with `en_hi`=0 or `en_lo_n`=1, or `ctl_strb_n`=0 with `en_n`=1, deselects the chip: no read occurs, no write occurs and the burst ends.
- R6: In an active burst with both strobes high, `adv_n`=0 moves to the next burst address. `adv_n`=1 repeats the current address. Either cycle reads, or writes if the combined write is active.
- R7: With `ilv_mode`=1 the low two address bits follow s, s^1, s^2, s^3, where s is the loaded start value.
- R8: With `ilv_mode`=0 the low two bits follow s, s+1, s+2, s+3 modulo 4. In both modes the upper address bits never change during a burst.
- R9: The combined write is active when `wr_all_n`=0, or when `wr_byte_n`=0 and any bit of `lane_n` is 0. `wr_all_n`=0 writes all lanes. Otherwise `lane_n[i]`=0 writes only lane i, which is `din[9i+8:9i]`.
- R10: After a read started by the processor strobe, asserting write in the next wait cycle (`adv_n`=1) writes `din` to the same address.
- R11: The word read for the address used at edge N appears on `dout` with `dout_en`=1 after edge N+1. Writes done at edge N+1 do not change it.
- R12: `dout_en` is 1 only while `oe_n`=0 and read data is present. `oe_n` acts without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| en_n | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| en_hi | input | 1 | Depth-expansion enable, active high |
| en_lo_n | input | 1 | Depth-expansion enable, active low |
| proc_strb_n | input | 1 | Processor address-load strobe, active low, always starts a read |
| ctl_strb_n | input | 1 | Controller address-load strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high means a wait cycle |
| wr_all_n | input | 1 | Global write, active low, writes all lanes |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| ilv_mode | input | 1 | 1 selects interleaved burst order, 0 selects linear order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench runs bursts from all four start values in both orders. A counter that wraps on the wrong bits, or that uses the wrong order, returns words from the wrong addresses. Strobe priority is tested in several ways: a processor strobe issued together with write controls, a processor strobe issued while the primary enable is high, and deselects through each enable. A design that gated the strobes wrongly would write, restart the burst or drive the bus when it should not. Lane-masked writes, a combined write that needs both the byte enable and a lane strobe, and a write in the wait cycle after a read all catch merge errors and write decode errors. Toggling the output enable between edges catches an enable that is registered instead of combinational.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
// Shared constants and the burst-order function for the pipelined burst RAM.
// Assumes a burst of four beats addressed by the two low address bits.
package burst_sram_pkg;
    localparam int BURST_BITS = 2;

    // Low address bits for beat k of a burst that started at s.
    function automatic logic [BURST_BITS-1:0] burst_lo(
        input logic [BURST_BITS-1:0] s,
        input logic [BURST_BITS-1:0] k,
        input logic                  interleave
    );
        return interleave ? (s ^ k) : (s + k);
    endfunction
endpackage

// File: rtl/bsram_wr_decode.sv
`timescale 1ns/1ps
// Write-control decode: builds the combined write flag and the per-lane
// write enables. Global write overrides the byte enable and the lane strobes.
// Assumes all inputs are active low, as they appear at the block edge.
module bsram_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    output logic             wr_any,
    output logic [LANES-1:0] lane_we
);
    // Lane enables: global write opens all lanes, otherwise the gated strobes.
    always_comb begin
        if (!wr_all_n)
            lane_we = '1;
        else if (!wr_byte_n)
            lane_we = ~lane_n;
        else
            lane_we = '0;
        wr_any = |lane_we;
    end
endmodule

// File: rtl/bsram_burst_ctl.sv
`timescale 1ns/1ps
// Burst controller: resolves strobe priority and chip select, keeps the
// burst base and the beat counter, and produces the address and the
// operation that apply at the coming edge. Assumes the mode input is stable
// for the length of a burst.
module bsram_burst_ctl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              proc_strb_n,
    input  logic              ctl_strb_n,
    input  logic              adv_n,
    input  logic              ilv_mode,
    input  logic              wr_any,
    output logic [ADDR_W-1:0] use_addr,
    output logic              do_read,
    output logic              do_write
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    logic                  active_q;
    logic [HI_W-1:0]       base_hi_q;
    logic [BURST_BITS-1:0] start_lo_q;
    logic [BURST_BITS-1:0] beat_q;

    logic                  sel, p_take, c_take, start, desel, cont;
    logic [BURST_BITS-1:0] beat_nx;

    // Strobe priority, chip select and the cycle type for this edge.
    always_comb begin
        sel     = !en_n && en_hi && !en_lo_n;
        p_take  = !proc_strb_n && !en_n;
        c_take  = !ctl_strb_n && !p_take;
        start   = (p_take || c_take) && sel;
        desel   = (p_take || c_take) && !sel;
        cont    = !p_take && !c_take && active_q;
        beat_nx = beat_q + BURST_BITS'(!adv_n);
    end

    // Address and operation used at the coming edge.
    always_comb begin
        if (start) begin
            use_addr = addr;
            do_read  = p_take || !wr_any;
            do_write = c_take && wr_any;
        end else begin
            use_addr = {base_hi_q, burst_lo(start_lo_q, beat_nx, ilv_mode)};
            do_read  = cont && !wr_any;
            do_write = cont && wr_any;
        end
    end

    // Burst state: load on start, clear on deselect, step on continue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            beat_q     <= '0;
            base_hi_q  <= '0;
            start_lo_q <= '0;
        end else if (start) begin
            active_q   <= 1'b1;
            beat_q     <= '0;
            base_hi_q  <= addr[ADDR_W-1:BURST_BITS];
            start_lo_q <= addr[BURST_BITS-1:0];
        end else if (desel) begin
            active_q   <= 1'b0;
        end else if (cont) begin
            beat_q     <= beat_nx;
        end
    end
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
// Storage array with lane-masked writes and a two-stage read pipeline:
// the address register is loaded at edge N and the data register at N+1.
// Assumes read and write never occur at the same edge.
module bsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       use_addr,
    input  logic                    do_read,
    input  logic                    do_write,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_v_q;

    // Lane-masked write into the array.
    always_ff @(posedge clk) begin
        if (do_write) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l])
                    mem[use_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
            end
        end
    end

    // Read pipeline: address stage, then data stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q    <= 1'b0;
            rvalid    <= 1'b0;
            rd_addr_q <= '0;
            rdata     <= '0;
        end else begin
            rd_v_q    <= do_read;
            rd_addr_q <= use_addr;
            rvalid    <= rd_v_q;
            if (rd_v_q)
                rdata <= mem[rd_addr_q];
        end
    end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
// Top level of the pipelined burst RAM. It ties together the write decode,
// the burst controller and the array, and gates the output drive with the
// asynchronous output enable. Assumes a single clock domain and a
// synchronous active-low reset.
module burst_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    en_n,
    input  logic                    en_hi,
    input  logic                    en_lo_n,
    input  logic                    proc_strb_n,
    input  logic                    ctl_strb_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    ilv_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    logic              wr_any, do_read, do_write, rvalid;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] use_addr;

    bsram_wr_decode #(.LANES(LANES)) u_dec (
        .wr_all_n (wr_all_n),
        .wr_byte_n(wr_byte_n),
        .lane_n   (lane_n),
        .wr_any   (wr_any),
        .lane_we  (lane_we)
    );

    bsram_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .en_n       (en_n),
        .en_hi      (en_hi),
        .en_lo_n    (en_lo_n),
        .proc_strb_n(proc_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .adv_n      (adv_n),
        .ilv_mode   (ilv_mode),
        .wr_any     (wr_any),
        .use_addr   (use_addr),
        .do_read    (do_read),
        .do_write   (do_write)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_addr(use_addr),
        .do_read (do_read),
        .do_write(do_write),
        .lane_we (lane_we),
        .din     (din),
        .rdata   (dout),
        .rvalid  (rvalid)
    );

    // Output drive: asynchronous enable over the registered valid flag.
    always_comb dout_en = rvalid && !oe_n;
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
// Checker for the burst RAM, attached to every instance through bind.
// It observes only the top-level ports.
module burst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic en_n,
    input logic en_hi,
    input logic en_lo_n,
    input logic proc_strb_n,
    input logic ctl_strb_n,
    input logic wr_all_n,
    input logic oe_n,
    input logic dout_en
);
    // R12
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dout_en);

    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strb_n && en_n) |=> ##1 !dout_en);

    // R2
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && !en_n && en_hi && !en_lo_n) |=> ##1 (dout_en || oe_n));

    // R4
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strb_n && proc_strb_n && !en_n && en_hi && !en_lo_n && !wr_all_n)
        |=> ##1 !dout_en);
endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_n       (en_n),
    .en_hi      (en_hi),
    .en_lo_n    (en_lo_n),
    .proc_strb_n(proc_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .wr_all_n   (wr_all_n),
    .oe_n       (oe_n),
    .dout_en    (dout_en)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks model each edge from the requirements and
// queue the expected read words; a monitor compares them at the falling edge.
module sim_burst_sram;
    localparam int AW = 8;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic en_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
    logic proc_strb_n = 1'b1, ctl_strb_n = 1'b1, adv_n = 1'b1;
    logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [3:0] lane_n = 4'hF;
    logic ilv_mode = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en;

    burst_sram u0 (.*);

    always #2.5 clk = ~clk;

    typedef struct { int due; logic [DW-1:0] data; int req; } exp_t;
    exp_t sb[$];
    int cyc = 0, checks = 0, fails = 0, cur_req = 0;
    logic [DW-1:0] mm [1 << AW];
    logic m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_k = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a + 8'd3, a[0], a ^ 8'hC3, ~a[0], a + 8'd77, a[1], ~a, a[2]};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp_v);
        end
    endtask

    // Drive one edge: model its effect from the requirements, queue reads.
    task automatic tick();
        logic sel, wr, p, c, rd, wt;
        logic [AW-1:0] ua;
        logic [3:0] en;
        sel = !en_n && en_hi && !en_lo_n;
        en  = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
        wr  = |en;
        p = !proc_strb_n && !en_n;
        c = !ctl_strb_n && !p;
        rd = 1'b0; wt = 1'b0; ua = addr;
        if (p || c) begin
            if (sel) begin
                m_act = 1'b1; m_base = addr; m_k = 2'd0;
                rd = p || !wr; wt = c && wr;
            end else m_act = 1'b0;
        end else if (m_act) begin
            if (!adv_n) m_k = m_k + 2'd1;
            ua = {m_base[AW-1:2], ilv_mode ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k)};
            rd = !wr; wt = wr;
        end
        if (rd) sb.push_back('{due: cyc + 2, data: mm[ua], req: cur_req});
        if (wt) for (int l = 0; l < 4; l++)
            if (en[l]) mm[ua][l*9 +: 9] = din[l*9 +: 9];
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        proc_strb_n = 1; ctl_strb_n = 1; adv_n = 1; wr_all_n = 1; wr_byte_n = 1;
        lane_n = 4'hF; en_n = 0; en_hi = 1; en_lo_n = 0; din = '0;
    endtask
    task automatic wr_c(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic g, input logic b, input logic [3:0] ln);
        nop(); ctl_strb_n = 0; addr = a; din = d; wr_all_n = g; wr_byte_n = b; lane_n = ln; tick();
    endtask
    task automatic rd_p(input logic [AW-1:0] a);
        nop(); proc_strb_n = 0; addr = a; tick();
    endtask
    task automatic rd_c(input logic [AW-1:0] a);
        nop(); ctl_strb_n = 0; addr = a; tick();
    endtask
    task automatic step(input logic advance);
        nop(); adv_n = !advance; tick();
    endtask
    task automatic desel();
        nop(); en_n = 1; ctl_strb_n = 0; tick();
        nop(); tick(); tick(); tick();
    endtask

    // Monitor: compare due items, flag any unexpected drive.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                checks++;
                if (!dout_en || dout !== sb[0].data) begin
                    fails++;
                    $display("FAIL R%0d read word actual=%h/en=%b expected=%h",
                             sb[0].req, dout, dout_en, sb[0].data);
                end
                void'(sb.pop_front());
            end else if (dout_en) begin
                checks++; fails++;
                $display("FAIL R%0d unexpected drive actual=%h expected=no drive", cur_req, dout);
            end
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        nop();
        repeat (3) @(posedge clk);
        #1;
        chk(dout_en === 1'b0, "R1 in reset", {35'd0, dout_en}, '0);
        rst_n = 1;
        @(posedge clk); #1;
        cur_req = 1; tick(); tick();
        chk(dout_en === 1'b0, "R1 after reset", {35'd0, dout_en}, '0);

        // Fill 0..31 with full-word writes started by the controller strobe (R4, R9)
        cur_req = 4;
        for (int a = 0; a < 32; a++) wr_c(AW'(a), pat(AW'(a)), 1'b0, 1'b1, 4'hF);
        desel();

        // Bursts from every start value in both orders (R7, R8, R11)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                ilv_mode = (m == 0);
                cur_req = (m == 0) ? 7 : 8;
                rd_p(AW'(8 + s));
                step(1); step(1); step(1);
                desel();
            end
        end
        ilv_mode = 1;

        // R2: processor strobe with global write low still reads, memory kept
        cur_req = 2;
        nop(); proc_strb_n = 0; addr = 8'd3; wr_all_n = 0; din = '1; tick();
        desel();
        rd_c(8'd3); desel();

        // R3: processor strobe while primary enable high continues the burst
        cur_req = 3;
        rd_c(8'd16);
        nop(); en_n = 1; proc_strb_n = 0; addr = 8'd30; adv_n = 0; tick();
        step(1);
        desel();

        // R5: deselect through each depth enable and through the primary one
        cur_req = 5;
        nop(); ctl_strb_n = 0; en_hi = 0; addr = 8'd4; tick();
        nop(); tick(); tick();
        nop(); proc_strb_n = 0; en_lo_n = 1; addr = 8'd5; tick();
        nop(); tick(); tick();
        chk(dout_en === 1'b0, "R5 deselected", {35'd0, dout_en}, '0);
        rd_c(8'd6); nop(); en_n = 1; ctl_strb_n = 0; wr_all_n = 0; din = '0; addr = 8'd6; tick();
        desel(); rd_c(8'd6); desel();

        // R6: wait cycles repeat the address, advance then moves on
        cur_req = 6;
        ilv_mode = 0;
        rd_c(8'd13); step(0); step(0); step(1); step(0); step(1);
        desel();
        ilv_mode = 1;

        // R9: lane-masked writes, byte enable gating, global override
        cur_req = 9;
        wr_c(8'd20, '0, 1'b0, 1'b1, 4'hF);
        wr_c(8'd20, '1, 1'b1, 1'b0, 4'b1010);
        desel(); rd_c(8'd20); desel();
        wr_c(8'd21, '1, 1'b1, 1'b1, 4'h0);
        desel(); rd_c(8'd21); desel();
        wr_c(8'd22, 36'h5_5555_5555, 1'b0, 1'b1, 4'hF);
        desel(); rd_c(8'd22); desel();
        wr_c(8'd23, '1, 1'b1, 1'b0, 4'b0111);
        desel(); rd_c(8'd23); desel();

        // R10: write in the wait cycle after a processor-strobe read
        cur_req = 10;
        rd_p(8'd25);
        nop(); wr_all_n = 0; din = 36'hA_BCDE_F012; tick();
        desel(); rd_c(8'd25); desel();

        // R12: output enable acts between edges
        cur_req = 12;
        rd_c(8'd2);
        nop(); en_n = 1; ctl_strb_n = 0; tick();
        oe_n = 1; #0.5;
        chk(dout_en === 1'b0, "R12 oe high", {35'd0, dout_en}, '0);
        oe_n = 0; #0.5;
        chk(dout_en === 1'b1 && dout === mm[2], "R12 oe low", dout, mm[2]);
        nop(); tick(); tick(); tick();

        chk(sb.size() == 0, "R11 queue drained", DW'(sb.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule